// File: doc/BRIEF.md
# Software-Driven Two-Wire Line Controller

This peripheral gives software direct control of the clock and data wires of a two-wire serial bus. A two-bit line state register sits behind two word addresses: one address sets state bits where the written data holds ones, the other clears them. Each state bit drives one wire as an open-drain output. A 0 pulls the wire low. A 1 lets the external pull-up raise it.

Software builds every bus event itself by toggling these bits and reading the data wire back. That covers start and stop conditions, bit shifting and acknowledge sampling. The data-wire input passes through a two-flop synchronizer. Its value is captured into a readable flag on every write, so a read returns the level seen at the most recent write. Accesses to addresses the block does not decode return all ones on reads and raise a one-cycle error pulse.

Top module: `i2c_line_ctl`

## Requirements
- R1: After reset both state bits are 1, so neither wire is pulled low. The captured data level reads 1 and the error output is low.
- R2: A write to offset 0x0 ORs write data bits [1:0] into the state, with bit 0 for the clock wire and bit 1 for the data wire. Bits that are already set stay set, and write data bits [31:2] have no effect.
- R3: A write to offset 0x4 clears every state bit whose matching write data bit in [1:0] is 1 and leaves the other bit unchanged.
- R4: While the address is 0x0, read data bit 0 is the clock-wire state bit and bit 1 is the captured data-wire level; bits [31:2] are 0.
- R5: While the address is any offset other than 0x0, read data is 0xFFFFFFFF.
- R6: A write to any offset other than 0x0 and 0x4 leaves the state unchanged.
- R7: The clock drive-low output is the inverse of state bit 0 and the data drive-low output is the inverse of state bit 1. Both take their new values in the cycle after the write edge.
- R8: Any write, at any offset, captures the synchronized data-wire input. It captures the pad level from two clock edges before the write edge. Between writes the captured level holds, even if the pad changes.
- R9: The error output is high for exactly the cycle after an edge with an undecoded access, and low otherwise. An undecoded access is a write to an offset other than 0x0 and 0x4, or a read strobe at an offset other than 0x0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte offset within the 4 KB window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, used only for decode errors |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| bus_err | output | 1 | One-cycle pulse after an undecoded access |
| scl_drive_low | output | 1 | Clock wire open-drain pull-down enable |
| sda_drive_low | output | 1 | Data wire open-drain pull-down enable |
| sda_pad_in | input | 1 | Data wire level from the pad |

## Verification
A wrong state bit is visible one cycle after the write that caused it: on a drive-low output, and at once on read data bit 0 for the clock wire. A bad capture of the data wire shows only in read bit 1, and only after the next write. The bench therefore reads back after every write and moves the pad between writes, which exposes a capture that happens too early or too often. Decode faults show up as a misplaced error pulse one cycle after the access, or as read data that is not all ones.

// File: rtl/i2c_line_ctl.sv
module i2c_line_ctl #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int SET_OFS = 0,
  parameter int CLR_OFS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  input  logic              sda_pad_in
);
  localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(SET_OFS);
  localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_OFS);

  logic [1:0] line_q;
  logic       sda_m, sda_s, sda_seen;

  wire hit_set = (bus_addr == SET_A);
  wire hit_clr = (bus_addr == CLR_A);
  wire bad_acc = (bus_wr && !hit_set && !hit_clr) || (bus_rd && !hit_set);
  wire unused_wdata_hi = |bus_wdata[DATA_W-1:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q   <= 2'b11;
      sda_m    <= 1'b1;
      sda_s    <= 1'b1;
      sda_seen <= 1'b1;
      bus_err  <= 1'b0;
    end else begin
      sda_m   <= sda_pad_in;
      sda_s   <= sda_m;
      bus_err <= bad_acc;
      if (bus_wr) begin
        if (hit_set)      line_q <= line_q | bus_wdata[1:0];
        else if (hit_clr) line_q <= line_q & ~bus_wdata[1:0];
        sda_seen <= sda_s;
      end
    end
  end

  assign scl_drive_low = ~line_q[0];
  assign sda_drive_low = ~line_q[1];
  assign bus_rdata = hit_set ? {{(DATA_W-2){1'b0}}, sda_seen, line_q[0]} : '1;

  assert_set_or_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_set) |=> ({~sda_drive_low, ~scl_drive_low} ==
                             ($past(line_q) | $past(bus_wdata[1:0]))));
  assert_clr_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_clr) |=> ({~sda_drive_low, ~scl_drive_low} ==
                             ($past(line_q) & ~$past(bus_wdata[1:0]))));
  assert_other_write_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !hit_set && !hit_clr) |=> $stable(line_q));
  assert_idle_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(line_q));
  assert_capture_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(sda_seen));
  assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_acc |=> bus_err);
  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_acc |=> !bus_err);
endmodule

// File: tb/tb_i2c_line_ctl.sv
module tb_i2c_line_ctl;
  logic        clk = 0, rst_n = 0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err, scl_drive_low, sda_drive_low;
  logic        sda_pad_in = 1;

  int total = 0, bad = 0;
  logic [1:0] exp_line = 2'b11;
  logic       exp_sda = 1'b1;

  i2c_line_ctl dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low), .sda_pad_in(sda_pad_in));

  always #4 clk = ~clk;

  function automatic logic [31:0] f_rdata(logic [11:0] a, logic [1:0] ln, logic s);
    return (a == 12'h0) ? {30'b0, s, ln[0]} : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [1:0] f_next(logic wr, logic [11:0] a, logic [31:0] d, logic [1:0] ln);
    if (!wr) return ln;
    if (a == 12'h0) return ln | d[1:0];
    if (a == 12'h4) return ln & ~d[1:0];
    return ln;
  endfunction

  function automatic logic f_bad(logic wr, logic rd, logic [11:0] a);
    return (wr && a != 12'h0 && a != 12'h4) || (rd && a != 12'h0);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(logic wr, logic rd, logic [11:0] a, logic [31:0] d);
    logic eb;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    #1;
    check((a == 0) ? "R4 read" : "R5 read", bus_rdata, f_rdata(a, exp_line, exp_sda));
    eb = f_bad(wr, rd, a);
    @(posedge clk);
    exp_line = f_next(wr, a, d, exp_line);
    if (wr) exp_sda = sda_pad_in;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    check("R9 err", {31'b0, bus_err}, {31'b0, eb});
    check((a == 4) ? "R3 state" : (a == 0 ? "R2 state" : "R6 state"),
          {30'b0, ~sda_drive_low, ~scl_drive_low}, {30'b0, exp_line});
    check("R7 scl", {31'b0, scl_drive_low}, {31'b0, ~exp_line[0]});
    check("R7 sda", {31'b0, sda_drive_low}, {31'b0, ~exp_line[1]});
  endtask

  task automatic set_pad(logic v);
    @(negedge clk);
    sda_pad_in = v;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    check("R1 scl", {31'b0, scl_drive_low}, 32'd0);
    check("R1 sda", {31'b0, sda_drive_low}, 32'd0);
    check("R1 err", {31'b0, bus_err}, 32'd0);
    bus_addr = 12'h0; #1;
    check("R1 rdata", bus_rdata, 32'h3);

    access(1, 0, 12'h4, 32'h3);
    access(0, 1, 12'h0, 0);
    access(1, 0, 12'h0, 32'hFFFF_FFFE);
    access(1, 0, 12'h0, 32'h0);
    access(0, 1, 12'h4, 0);
    access(0, 1, 12'hFFC, 0);
    access(1, 0, 12'h10, 32'h3);
    access(1, 0, 12'h4, 32'hFFFF_FFFD);
    set_pad(0);
    access(0, 1, 12'h0, 0);
    access(1, 0, 12'h8, 32'h0);
    access(0, 1, 12'h0, 0);
    set_pad(1);
    access(0, 1, 12'h0, 0);
    access(1, 0, 12'h4, 32'h0);
    access(0, 1, 12'h0, 0);

    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      logic wr, rd;
      case ($urandom % 4)
        0: a = 12'h0;
        1: a = 12'h4;
        2: a = 12'($urandom % 1024) << 2;
        default: a = 12'($urandom);
      endcase
      wr = 1'($urandom);
      rd = !wr && 1'($urandom);
      if (($urandom % 8) == 0) set_pad(1'($urandom));
      access(wr, rd, a, $urandom);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule